// File: doc/BRIEF.md
# Text Console Command Controller

This block sits between a simple memory-mapped register bus and the write port of an 80-column by 25-row character screen buffer. Each buffer cell holds a character code together with a foreground and a background colour index. A processor drives a 32-bit address, 32-bit write data and a one-cycle write strobe. The block turns those bus writes into cell writes, and a combinational 32-bit read-back bus returns register and cell contents.

The block has two modes. In normal mode it behaves like a teletype. It keeps a carriage (column, row) and the current colour pair. When a character code is written, it packs the code with the colours into a cell, stores it under the carriage and moves the carriage along. In low-level mode the processor addresses raw cells directly. It can write a cell without moving the pointer, or write and post-increment the pointer. The read-back port returns the cell under the raw pointer.

The buffer RAM itself is outside the block. The block provides the registered write port and a read address, and it takes the RAM's read data.

Top module: `tcon_cmd_top`

## Requirements
- R1: A cell is 18 bits: background index in bits 17:13, foreground index in bits 12:8, character code in bits 7:0.
- R2: Writing offset 302 sets the carriage column to the write data. Any data value above 79 sets the column to 0.
- R3: Writing offset 303 sets the carriage row to the write data. Any data value above 24 sets the row to 0.
- R4: Writing offset 304 sets the foreground index and writing offset 305 sets the background index. Each takes data bits 4:0.
- R5: In normal mode, a write to offset 306 raises the write strobe one clock later for one cycle. The write address is row*80+column of the carriage before the write, and the write data is {background, foreground, data[7:0]}.
- R6: After each such emit the column increments. Past column 79 the column becomes 0 and the row increments, and past row 24 the row becomes 0.
- R7: Writing offset 308 (carriage return, any mode) sets the column to 0 and increments the row, with row 24 wrapping to 0.
- R8: Offset 307 selects the mode from data bit 0: 1 is low-level, 0 is normal. In normal mode, writes to 300, 301 and 309 have no effect. In low-level mode, writes to 306 have no effect.
- R9: In low-level mode, writing offset 301 sets the raw pointer. Any data value above 1999 sets it to 0.
- R10: In low-level mode, a write to offset 300 writes data[17:0] to the cell at the raw pointer one clock later and leaves the pointer unchanged.
- R11: In low-level mode, a write to offset 309 writes data[17:0] to the cell at the raw pointer one clock later and then increments the pointer, with 1999 wrapping to 0.
- R12: Read-back is combinational on the address. Offset 300 returns the RAM read data (whose read address is the raw pointer) zero-extended. Offset 301 returns the raw pointer, 302 the column, 303 the row, 304 the foreground index, 305 the background index and 307 the mode bit. Every other offset returns 0.
- R13: After reset the column, row, background index, raw pointer and mode are 0 (normal), the foreground index is 7 and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Register offset for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read-back |
| scr_we | output | 1 | Buffer write enable (registered) |
| scr_waddr | output | 11 | Buffer write cell address |
| scr_wdata | output | 18 | Buffer write cell data |
| scr_raddr | output | 11 | Buffer read address (raw pointer) |
| scr_rdata | input | 18 | Buffer read data |

## Verification
All state changes and buffer writes appear exactly one clock after the edge that sampled the bus write. The bench therefore drives each transfer on a falling edge and updates its behavioural model at the following rising edge. It compares the write port on the next falling edge. Register read-back is combinational, so it is sampled a nanosecond after the address is driven. A cell read through offset 300 passes through the bench's synchronous RAM, which costs one edge for the write and another for the read. For that reason the bench inserts two idle cycles before comparing a cell read.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
  localparam int COLS   = 80;
  localparam int ROWS   = 25;
  localparam int CELLS  = COLS * ROWS;
  localparam int AW     = $clog2(CELLS);
  localparam int CW     = $clog2(COLS);
  localparam int RW     = $clog2(ROWS);
  localparam int CLRW   = 5;
  localparam int CHW    = 8;
  localparam int CELLW  = CHW + 2 * CLRW;
  localparam logic [CLRW-1:0] FG_RESET = CLRW'(7);

  localparam logic [31:0] OFS_CELL  = 32'd300;
  localparam logic [31:0] OFS_PTR   = 32'd301;
  localparam logic [31:0] OFS_COL   = 32'd302;
  localparam logic [31:0] OFS_ROW   = 32'd303;
  localparam logic [31:0] OFS_FG    = 32'd304;
  localparam logic [31:0] OFS_BG    = 32'd305;
  localparam logic [31:0] OFS_EMIT  = 32'd306;
  localparam logic [31:0] OFS_MODE  = 32'd307;
  localparam logic [31:0] OFS_CR    = 32'd308;
  localparam logic [31:0] OFS_PUSH  = 32'd309;

  typedef struct packed {
    logic [CLRW-1:0] bg;
    logic [CLRW-1:0] fg;
    logic [CHW-1:0]  ch;
  } cell_t;

  typedef struct packed {
    logic cell_wr;
    logic ptr_set;
    logic col_set;
    logic row_set;
    logic fg_set;
    logic bg_set;
    logic emit;
    logic mode_set;
    logic cr;
    logic push;
  } hit_t;

  function automatic logic [CW-1:0] col_inc(input logic [CW-1:0] c);
    return (c == CW'(COLS - 1)) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [RW-1:0] row_inc(input logic [RW-1:0] r);
    return (r == RW'(ROWS - 1)) ? '0 : r + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] a);
    return (a == AW'(CELLS - 1)) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [CW-1:0] col_load(input logic [31:0] d);
    return (d > 32'(COLS - 1)) ? '0 : d[CW-1:0];
  endfunction

  function automatic logic [RW-1:0] row_load(input logic [31:0] d);
    return (d > 32'(ROWS - 1)) ? '0 : d[RW-1:0];
  endfunction

  function automatic logic [AW-1:0] ptr_load(input logic [31:0] d);
    return (d > 32'(CELLS - 1)) ? '0 : d[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] pos_addr(input logic [RW-1:0] r,
                                             input logic [CW-1:0] c);
    return AW'(int'(r) * COLS + int'(c));
  endfunction
endpackage

// File: rtl/tcon_decode.sv
module tcon_decode
  import tcon_pkg::*;
(
  input  logic [31:0] bus_addr,
  input  logic        bus_wr,
  input  logic        mode_raw,
  output hit_t        hit
);
  always_comb begin
    hit          = '0;
    hit.col_set  = bus_wr && (bus_addr == OFS_COL);
    hit.row_set  = bus_wr && (bus_addr == OFS_ROW);
    hit.fg_set   = bus_wr && (bus_addr == OFS_FG);
    hit.bg_set   = bus_wr && (bus_addr == OFS_BG);
    hit.mode_set = bus_wr && (bus_addr == OFS_MODE);
    hit.cr       = bus_wr && (bus_addr == OFS_CR);
    hit.emit     = bus_wr && !mode_raw && (bus_addr == OFS_EMIT);
    hit.cell_wr  = bus_wr &&  mode_raw && (bus_addr == OFS_CELL);
    hit.ptr_set  = bus_wr &&  mode_raw && (bus_addr == OFS_PTR);
    hit.push     = bus_wr &&  mode_raw && (bus_addr == OFS_PUSH);
  end
endmodule

// File: rtl/tcon_carriage.sv
module tcon_carriage
  import tcon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  hit_t            hit,
  input  logic [31:0]     wdata,
  output logic [CW-1:0]   col,
  output logic [RW-1:0]   row,
  output logic [CLRW-1:0] fg,
  output logic [CLRW-1:0] bg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      fg  <= FG_RESET;
      bg  <= '0;
    end else begin
      if (hit.col_set) col <= col_load(wdata);
      if (hit.row_set) row <= row_load(wdata);
      if (hit.fg_set)  fg  <= wdata[CLRW-1:0];
      if (hit.bg_set)  bg  <= wdata[CLRW-1:0];
      if (hit.emit) begin
        col <= col_inc(col);
        if (col == CW'(COLS - 1)) row <= row_inc(row);
      end
      if (hit.cr) begin
        col <= '0;
        row <= row_inc(row);
      end
    end
  end
endmodule

// File: rtl/tcon_rawptr.sv
module tcon_rawptr
  import tcon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  hit_t          hit,
  input  logic [31:0]   wdata,
  output logic          mode_raw,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_raw <= 1'b0;
      ptr      <= '0;
    end else begin
      if (hit.mode_set) mode_raw <= wdata[0];
      if (hit.ptr_set)  ptr      <= ptr_load(wdata);
      if (hit.push)     ptr      <= ptr_inc(ptr);
    end
  end
endmodule

// File: rtl/tcon_cmd_top.sv
module tcon_cmd_top
  import tcon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  output logic              scr_we,
  output logic [AW-1:0]     scr_waddr,
  output logic [CELLW-1:0]  scr_wdata,
  output logic [AW-1:0]     scr_raddr,
  input  logic [CELLW-1:0]  scr_rdata
);
  hit_t            hit;
  logic            mode_raw;
  logic [AW-1:0]   raw_ptr;
  logic [CW-1:0]   car_col;
  logic [RW-1:0]   car_row;
  logic [CLRW-1:0] cur_fg;
  logic [CLRW-1:0] cur_bg;
  logic            emit_go;
  logic            raw_go;
  logic            push_go;
  cell_t           packed_cell;

  tcon_decode u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .mode_raw (mode_raw),
    .hit      (hit)
  );

  tcon_carriage u_car (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .wdata (bus_wdata),
    .col   (car_col),
    .row   (car_row),
    .fg    (cur_fg),
    .bg    (cur_bg)
  );

  tcon_rawptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .wdata    (bus_wdata),
    .mode_raw (mode_raw),
    .ptr      (raw_ptr)
  );

  assign emit_go = hit.emit;
  assign raw_go  = hit.cell_wr;
  assign push_go = hit.push;

  always_comb begin
    packed_cell.bg = cur_bg;
    packed_cell.fg = cur_fg;
    packed_cell.ch = bus_wdata[CHW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_we    <= 1'b0;
      scr_waddr <= '0;
      scr_wdata <= '0;
    end else begin
      scr_we <= emit_go | raw_go | push_go;
      if (emit_go) begin
        scr_waddr <= pos_addr(car_row, car_col);
        scr_wdata <= packed_cell;
      end else if (raw_go | push_go) begin
        scr_waddr <= raw_ptr;
        scr_wdata <= bus_wdata[CELLW-1:0];
      end
    end
  end

  assign scr_raddr = raw_ptr;

  always_comb begin
    case (bus_addr)
      OFS_CELL: bus_rdata = 32'(scr_rdata);
      OFS_PTR:  bus_rdata = 32'(raw_ptr);
      OFS_COL:  bus_rdata = 32'(car_col);
      OFS_ROW:  bus_rdata = 32'(car_row);
      OFS_FG:   bus_rdata = 32'(cur_fg);
      OFS_BG:   bus_rdata = 32'(cur_bg);
      OFS_MODE: bus_rdata = 32'(mode_raw);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tcon_chk.sv
module tcon_chk
  import tcon_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     bus_addr,
  input logic            bus_wr,
  input logic            scr_we,
  input logic [AW-1:0]   scr_waddr,
  input logic [CW-1:0]   car_col,
  input logic [RW-1:0]   car_row,
  input logic [AW-1:0]   raw_ptr,
  input logic            mode_raw,
  input logic            emit_go,
  input logic            push_go
);
  // R5
  emit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_go |=> scr_we && (int'(scr_waddr) == int'($past(car_row)) * COLS + int'($past(car_col))));

  // R6
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(car_col) < COLS);

  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(car_row) < ROWS);

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(raw_ptr) < CELLS);

  // R11
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> (int'(raw_ptr) == ((int'($past(raw_ptr)) == CELLS - 1) ? 0 : int'($past(raw_ptr)) + 1)));

  // R8
  emit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mode_raw && bus_addr == OFS_EMIT) |=> !scr_we);

  // R8
  we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scr_we) |-> $past(bus_wr));
endmodule

bind tcon_cmd_top tcon_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .scr_we    (scr_we),
  .scr_waddr (scr_waddr),
  .car_col   (car_col),
  .car_row   (car_row),
  .raw_ptr   (raw_ptr),
  .mode_raw  (mode_raw),
  .emit_go   (emit_go),
  .push_go   (push_go)
);

// File: tb/tcon_cmd_top_tb_top.sv
module tcon_cmd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        scr_we;
  logic [10:0] scr_waddr;
  logic [17:0] scr_wdata;
  logic [10:0] scr_raddr;
  logic [17:0] ram_q = '0;
  logic [17:0] bmem [0:1999];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_col, m_row, m_fg, m_bg, m_mode, m_ptr;
  int ref_mem [0:1999];
  bit e_we;
  int e_wa, e_wd;

  always #10 clk = ~clk;

  tcon_cmd_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .scr_we    (scr_we),
    .scr_waddr (scr_waddr),
    .scr_wdata (scr_wdata),
    .scr_raddr (scr_raddr),
    .scr_rdata (ram_q)
  );

  always @(posedge clk) begin
    if (scr_we) bmem[scr_waddr] <= scr_wdata;
    ram_q <= bmem[scr_raddr];
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      300: return ref_mem[m_ptr];
      301: return m_ptr;
      302: return m_col;
      303: return m_row;
      304: return m_fg;
      305: return m_bg;
      307: return m_mode;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input int a, input logic [31:0] d, input bit w);
    e_we = 0;
    if (w) begin
      case (a)
        300: if (m_mode == 1) begin e_we = 1; e_wa = m_ptr; e_wd = int'(d & 32'h3FFFF); end
        301: if (m_mode == 1) m_ptr = (d > 32'd1999) ? 0 : int'(d);
        302: m_col = (d > 32'd79) ? 0 : int'(d);
        303: m_row = (d > 32'd24) ? 0 : int'(d);
        304: m_fg = int'(d & 32'h1F);
        305: m_bg = int'(d & 32'h1F);
        306: if (m_mode == 0) begin
          e_we = 1; e_wa = m_row * 80 + m_col;
          e_wd = (m_bg << 13) | (m_fg << 8) | int'(d & 32'hFF);
          m_col++;
          if (m_col == 80) begin m_col = 0; m_row = (m_row == 24) ? 0 : m_row + 1; end
        end
        307: m_mode = int'(d & 1);
        308: begin m_col = 0; m_row = (m_row == 24) ? 0 : m_row + 1; end
        309: if (m_mode == 1) begin
          e_we = 1; e_wa = m_ptr; e_wd = int'(d & 32'h3FFFF);
          m_ptr = (m_ptr == 1999) ? 0 : m_ptr + 1;
        end
        default: ;
      endcase
      if (e_we) ref_mem[e_wa] = e_wd;
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, compare write port at next falling edge
  task automatic step(input int a, input logic [31:0] d, input bit w, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr = w;
    @(posedge clk);
    model_step(a, d, w);
    @(negedge clk);
    chk({tag, " we"}, scr_we, e_we);
    if (e_we) begin
      chk({tag, " waddr"}, scr_waddr, e_wa);
      chk({tag, " wdata"}, scr_wdata, e_wd);
    end
    bus_wr = 0;
  endtask

  task automatic rd(input int a, input string tag);
    bus_addr = a; bus_wr = 0;
    #1;
    chk({tag, " read"}, bus_rdata, model_read(a));
    step(a, 0, 0, tag);
  endtask

  task automatic rd_cell(input string tag);
    step(0, 0, 0, tag);
    step(0, 0, 0, tag);
    rd(300, tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2000; i++) begin bmem[i] = '0; ref_mem[i] = 0; end
    m_col = 0; m_row = 0; m_fg = 7; m_bg = 0; m_mode = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    chk("R13 we", scr_we, 0);
    rd(302, "R13 col"); rd(303, "R13 row"); rd(304, "R13 fg");
    rd(305, "R13 bg"); rd(307, "R13 mode"); rd(301, "R13 ptr");
    // R2
    step(302, 10, 1, "R2"); rd(302, "R2 set");
    step(302, 80, 1, "R2"); rd(302, "R2 over");
    step(302, 79, 1, "R2"); rd(302, "R2 edge");
    // R3
    step(303, 24, 1, "R3"); rd(303, "R3 edge");
    step(303, 25, 1, "R3"); rd(303, "R3 over");
    step(303, 32'hFFFF_FFFF, 1, "R3"); rd(303, "R3 big");
    // R4
    step(304, 32'h23, 1, "R4"); rd(304, "R4 fg");
    step(305, 9, 1, "R4"); rd(305, "R4 bg");
    // R1 R5 R6 emit and wrap
    step(302, 78, 1, "R6"); step(303, 3, 1, "R6");
    step(306, 32'h141, 1, "R1 R5 emit");
    step(306, 32'h42, 1, "R5 emit");
    rd(302, "R6 col wrap"); rd(303, "R6 row step");
    step(302, 79, 1, "R6"); step(303, 24, 1, "R6");
    step(306, 32'h43, 1, "R6 emit corner");
    rd(302, "R6 col end"); rd(303, "R6 row end");
    // R7
    step(302, 5, 1, "R7"); step(303, 7, 1, "R7");
    step(308, 0, 1, "R7 cr"); rd(302, "R7 col"); rd(303, "R7 row");
    step(303, 24, 1, "R7"); step(308, 0, 1, "R7 cr wrap"); rd(303, "R7 row wrap");
    // R8 gating in normal mode
    step(300, 32'h1234, 1, "R8 cell ignored");
    step(309, 32'h1234, 1, "R8 push ignored");
    step(301, 55, 1, "R8 ptr ignored"); rd(301, "R8 ptr");
    step(307, 1, 1, "R8 mode"); rd(307, "R8 mode read");
    step(306, 32'h44, 1, "R8 emit ignored"); rd(302, "R8 col kept");
    // R9
    step(301, 1998, 1, "R9"); rd(301, "R9 set");
    step(301, 2000, 1, "R9"); rd(301, "R9 over");
    step(301, 1998, 1, "R9");
    // R11
    step(309, 32'hFFFC_0123, 1, "R11 push");
    step(309, 32'h2AAAA, 1, "R11 push end");
    rd(301, "R11 wrap");
    // R10
    step(300, 32'hFFFF_FFFF, 1, "R10 cell"); rd(301, "R10 ptr kept");
    // R12
    rd_cell("R12 cell");
    step(301, 1999, 1, "R12"); rd_cell("R12 cell2");
    rd(400, "R12 other"); rd(306, "R12 emit reg");
    step(307, 0, 1, "R8 back");
    // mixed traffic compared every clock
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [31:0] d;
      a = 300 + $urandom_range(0, 9);
      d = (a == 301) ? $urandom_range(0, 2100) : $urandom_range(0, 300);
      if (a == 307 && $urandom_range(0, 3) != 0) d = m_mode;
      step(a, d, 1, "R5 R10 R11 mix");
      if (a != 300 && a != 309) rd(a, "R12 mix");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule